// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge lets a host reach an internal 32-bit register bus through four mailbox words: an address word, a data word, a command word and a status word. The host picks a word with a two-bit selector. Before an access it clears the status word. It then loads the address word, and for a write it also loads the data word. A write to the command word starts exactly one transaction on the internal bus. The host then polls the status word until the done bit or the error bit appears. After a successful read it fetches the returned value from the data word.

On the internal side the bridge is a master with two valid/ready channels. On the request channel, `bus_req_valid` rises the cycle after a command write is accepted. The request then holds with stable fields until the slave raises `bus_req_ready`, so the slave applies back-pressure by holding ready low. On the response channel, the bridge raises `bus_rsp_ready` only while it waits for an answer. The response is taken on the first edge where `bus_rsp_valid` is high. Each command gives one request and one response, with no bursts.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the address, data and status words read as zero, `bus_req_valid` is low and `bus_rsp_ready` is low.
- R2: A host write of any value to the status word (selector 3) clears the done bit (bit 0) and the error bit (bit 1). If a response completes in the same cycle, the completion wins.
- R3: While idle, a write to the command word (selector 2) with bit 0 clear starts a read. On the next cycle `bus_req_valid` is high, `bus_req_write` is low and `bus_req_addr` equals all 32 bits of the address word (selector 0).
- R4: While idle, a write to the command word with bit 0 set starts a write. The request carries `bus_req_write` high, the address word, and the data word (selector 1) as it stood at the start.
- R5: A request stays valid, with all its fields stable, until the edge where `bus_req_ready` is high. After that handshake `bus_req_valid` is low, and exactly one request is issued for each start.
- R6: A read response without error places `bus_rsp_rdata` in the data word and sets the done bit. Both are visible right after the edge that accepts the response.
- R7: A response with `bus_rsp_err` high sets the error bit and not the done bit, and leaves the data word unchanged.
- R8: While a transaction is in flight after the status word was cleared, the status word reads zero.
- R9: A command write while a transaction is in flight is ignored. The running transaction keeps its address and direction, and no second request follows it.
- R10: The done and error bits are sticky. Writes to the address or data words while idle leave the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for the selected mailbox word |
| host_sel | input | 2 | Mailbox word select: 0 address, 1 data, 2 command, 3 status |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Selected mailbox word (command reads zero) |
| bus_req_valid | output | 1 | Internal request valid |
| bus_req_ready | input | 1 | Internal request ready from the slave |
| bus_req_write | output | 1 | Request direction, 1 for write |
| bus_req_addr | output | 32 | Request address |
| bus_req_wdata | output | 32 | Request write data |
| bus_rsp_valid | input | 1 | Response valid from the slave |
| bus_rsp_ready | output | 1 | Bridge waiting for a response |
| bus_rsp_err | input | 1 | Response reports an error |
| bus_rsp_rdata | input | 32 | Response read data |

## Verification
A command write registered at one rising edge makes the request visible right after that edge. The bench therefore checks request fields at the falling edge that follows. A handshake or response driven at a falling edge is taken at the next rising edge. Status and data are read back combinationally at the falling edge after that rising edge, so every check samples half a cycle after the edge that produced its result. During request and response waits the bench checks at every falling edge that the request is stable and the status still reads zero.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;
  localparam logic [1:0] SEL_STS  = 2'd3;

  localparam int STS_DONE_BIT = 0;
  localparam int STS_ERR_BIT  = 1;
  localparam int CMD_WR_BIT   = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } ibr_state_e;
endpackage

// File: rtl/ibr_regs.sv
module ibr_regs
  import ibr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_en,
  input  logic [1:0]    host_sel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          cmp_fire,
  input  logic          cmp_err,
  input  logic          cmp_is_read,
  input  logic [DW-1:0] cmp_rdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          cmd_wr,
  output logic          cmd_write_flag
);
  logic sts_done, sts_err;
  logic wr_addr, wr_data, wr_sts;

  assign wr_addr = host_wr_en && (host_sel == SEL_ADDR);
  assign wr_data = host_wr_en && (host_sel == SEL_DATA);
  assign wr_sts  = host_wr_en && (host_sel == SEL_STS);
  assign cmd_wr  = host_wr_en && (host_sel == SEL_CMD);
  assign cmd_write_flag = host_wdata[CMD_WR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_addr) begin
      addr_q <= host_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cmp_fire && !cmp_err && cmp_is_read) begin
      data_q <= cmp_rdata;
    end else if (wr_data) begin
      data_q <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_done <= 1'b0;
      sts_err  <= 1'b0;
    end else if (cmp_fire) begin
      if (cmp_err) sts_err <= 1'b1;
      else         sts_done <= 1'b1;
    end else if (wr_sts) begin
      sts_done <= 1'b0;
      sts_err  <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_sel)
      SEL_ADDR: host_rdata[AW-1:0] = addr_q;
      SEL_DATA: host_rdata = data_q;
      SEL_STS: begin
        host_rdata[STS_DONE_BIT] = sts_done;
        host_rdata[STS_ERR_BIT]  = sts_err;
      end
      default: host_rdata = '0;
    endcase
  end

  // R2: a status write without a completion in the same cycle clears both bits
  assert_sts_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && !cmp_fire) |=> (!sts_done && !sts_err));

  // R7: an error response raises the error bit and keeps the data word
  assert_err_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && cmp_err && !wr_data) |=> (sts_err && $stable(data_q)));

  // R10: address or data writes leave the status bits alone
  assert_sticky_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_addr || wr_data) && !cmp_fire) |=> ($stable(sts_done) && $stable(sts_err)));
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
  import ibr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          cmd_write_flag,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] data_q,
  output logic          bus_req_valid,
  input  logic          bus_req_ready,
  output logic          bus_req_write,
  output logic [AW-1:0] bus_req_addr,
  output logic [DW-1:0] bus_req_wdata,
  input  logic          bus_rsp_valid,
  output logic          bus_rsp_ready,
  input  logic          bus_rsp_err,
  input  logic [DW-1:0] bus_rsp_rdata,
  output logic          cmp_fire,
  output logic          cmp_err,
  output logic          cmp_is_read,
  output logic [DW-1:0] cmp_rdata
);
  ibr_state_e    state;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  logic          lat_write;
  logic          idle;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_write <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_wr) begin
          lat_addr  <= addr_q;
          lat_wdata <= data_q;
          lat_write <= cmd_write_flag;
          state     <= ST_REQ;
        end
        ST_REQ:  if (bus_req_ready) state <= ST_RSP;
        ST_RSP:  if (bus_rsp_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_valid = (state == ST_REQ);
  assign bus_rsp_ready = (state == ST_RSP);
  assign bus_req_write = lat_write;
  assign bus_req_addr  = lat_addr;
  assign bus_req_wdata = lat_wdata;

  assign cmp_fire    = bus_rsp_ready && bus_rsp_valid;
  assign cmp_err     = bus_rsp_err;
  assign cmp_is_read = !lat_write;
  assign cmp_rdata   = bus_rsp_rdata;

  // R3: an accepted command makes a request visible on the next cycle
  assert_start_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_wr) |=> bus_req_valid);

  // R5: a stalled request holds all its fields
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=>
      (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_wdata) && $stable(bus_req_write)));

  // R5: one request per start, valid drops after the handshake
  assert_single_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_ready) |=> !bus_req_valid);

  // R9: a command while busy does not disturb the running transaction
  assert_busy_cmd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cmd_wr) |=> ($stable(bus_req_addr) && $stable(bus_req_write)));
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_en,
  input  logic [1:0]    host_sel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          bus_req_valid,
  input  logic          bus_req_ready,
  output logic          bus_req_write,
  output logic [AW-1:0] bus_req_addr,
  output logic [DW-1:0] bus_req_wdata,
  input  logic          bus_rsp_valid,
  output logic          bus_rsp_ready,
  input  logic          bus_rsp_err,
  input  logic [DW-1:0] bus_rsp_rdata
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          cmd_wr, cmd_write_flag;
  logic          cmp_fire, cmp_err, cmp_is_read;
  logic [DW-1:0] cmp_rdata;

  ibr_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmp_fire(cmp_fire), .cmp_err(cmp_err),
    .cmp_is_read(cmp_is_read), .cmp_rdata(cmp_rdata),
    .addr_q(addr_q), .data_q(data_q),
    .cmd_wr(cmd_wr), .cmd_write_flag(cmd_write_flag)
  );

  ibr_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_write_flag(cmd_write_flag),
    .addr_q(addr_q), .data_q(data_q),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_ready(bus_rsp_ready),
    .bus_rsp_err(bus_rsp_err), .bus_rsp_rdata(bus_rsp_rdata),
    .cmp_fire(cmp_fire), .cmp_err(cmp_err),
    .cmp_is_read(cmp_is_read), .cmp_rdata(cmp_rdata)
  );
endmodule

// File: tb/ibr_bridge_tb.sv
`timescale 1ns/1ps
module ibr_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        bus_req_valid, bus_req_write, bus_rsp_ready;
  logic [31:0] bus_req_addr, bus_req_wdata;
  logic        bus_req_ready = 1'b0;
  logic        bus_rsp_valid = 1'b0;
  logic        bus_rsp_err = 1'b0;
  logic [31:0] bus_rsp_rdata = '0;

  int total = 0;
  int bad = 0;
  logic [31:0] model_data;

  always #2.5 clk = ~clk;

  ibr_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_ready(bus_rsp_ready),
    .bus_rsp_err(bus_rsp_err), .bus_rsp_rdata(bus_rsp_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        err;
    logic [3:0]  reqw;
    logic [3:0]  rspw;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0010, 32'h0,          32'hA5A5_0001, 1'b0, 4'd0, 4'd0},
    '{1'b1, 32'h0000_0020, 32'h1234_5678,  32'h0,         1'b0, 4'd2, 4'd1},
    '{1'b0, 32'hFFFF_FFFC, 32'h0,          32'h5555_AAAA, 1'b1, 4'd1, 4'd3},
    '{1'b0, 32'h8000_0004, 32'h0,          32'hDEAD_BEEF, 1'b0, 4'd3, 4'd0},
    '{1'b1, 32'hC000_0000, 32'h0BAD_0BAD,  32'h0,         1'b1, 4'd0, 4'd2},
    '{1'b0, 32'h7FFF_FFF0, 32'h0,          32'h0000_0000, 1'b0, 4'd1, 4'd1}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [31:0] val);
    host_wr_en = 1'b1;
    host_sel   = sel;
    host_wdata = val;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [31:0] val);
    host_sel = sel;
    #0.5;
    val = host_rdata;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [31:0] r;
    host_write(2'd3, 32'h0);
    host_write(2'd0, v.addr);
    if (v.wr) begin
      host_write(2'd1, v.wdata);
      model_data = v.wdata;
    end
    host_write(2'd2, {31'h0, v.wr});
    for (int i = 0; i < int'(v.reqw); i++) begin
      check($sformatf("R5 hold valid v%0d", idx), {31'h0, bus_req_valid}, 32'h1);
      host_read(2'd3, r);
      check($sformatf("R8 status in flight v%0d", idx), r, 32'h0);
      @(negedge clk);
    end
    check($sformatf("R3 req valid v%0d", idx), {31'h0, bus_req_valid}, 32'h1);
    check($sformatf("R3 req addr v%0d", idx), bus_req_addr, v.addr);
    check($sformatf("R4 req dir v%0d", idx), {31'h0, bus_req_write}, {31'h0, v.wr});
    if (v.wr) check($sformatf("R4 req wdata v%0d", idx), bus_req_wdata, v.wdata);
    bus_req_ready = 1'b1;
    @(negedge clk);
    bus_req_ready = 1'b0;
    check($sformatf("R5 valid drops v%0d", idx), {31'h0, bus_req_valid}, 32'h0);
    for (int i = 0; i < int'(v.rspw); i++) begin
      host_read(2'd3, r);
      check($sformatf("R8 status wait rsp v%0d", idx), r, 32'h0);
      @(negedge clk);
    end
    bus_rsp_valid = 1'b1;
    bus_rsp_err   = v.err;
    bus_rsp_rdata = v.rdata;
    @(negedge clk);
    bus_rsp_valid = 1'b0;
    bus_rsp_err   = 1'b0;
    if (!v.wr && !v.err) model_data = v.rdata;
    host_read(2'd3, r);
    if (v.err) check($sformatf("R7 status err v%0d", idx), r, 32'h2);
    else       check($sformatf("R6 status done v%0d", idx), r, 32'h1);
    host_read(2'd1, r);
    if (v.err) check($sformatf("R7 data kept v%0d", idx), r, model_data);
    else       check($sformatf("R6 data word v%0d", idx), r, model_data);
    check($sformatf("R5 no second req v%0d", idx), {31'h0, bus_req_valid}, 32'h0);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    model_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    host_read(2'd0, r); check("R1 addr reset", r, 32'h0);
    host_read(2'd1, r); check("R1 data reset", r, 32'h0);
    host_read(2'd3, r); check("R1 status reset", r, 32'h0);
    check("R1 req valid reset", {31'h0, bus_req_valid}, 32'h0);
    check("R1 rsp ready reset", {31'h0, bus_rsp_ready}, 32'h0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

    // R10 sticky done across address/data writes
    host_write(2'd0, 32'h0000_0444);
    host_write(2'd1, 32'h0000_0555);
    model_data = 32'h0000_0555;
    host_read(2'd3, r); check("R10 status sticky", r, 32'h1);

    // R2 nonzero value written to status still clears
    host_write(2'd3, 32'hFFFF_FFFF);
    host_read(2'd3, r); check("R2 status cleared", r, 32'h0);

    // R9 command while busy is ignored
    host_write(2'd0, 32'h0000_0A10);
    host_write(2'd2, 32'h0);
    host_write(2'd0, 32'h0000_0B20);
    host_write(2'd2, 32'h1);
    check("R9 addr kept", bus_req_addr, 32'h0000_0A10);
    check("R9 dir kept", {31'h0, bus_req_write}, 32'h0);
    bus_req_ready = 1'b1;
    @(negedge clk);
    bus_req_ready = 1'b0;
    host_write(2'd2, 32'h1);
    // R2 completion in the same cycle as a status write wins
    bus_rsp_valid = 1'b1;
    bus_rsp_rdata = 32'h0C0F_FEE0;
    host_write(2'd3, 32'h0);
    bus_rsp_valid = 1'b0;
    host_read(2'd3, r); check("R2 completion wins", r, 32'h1);
    host_read(2'd1, r); check("R9 read data", r, 32'h0C0F_FEE0);
    repeat (2) @(negedge clk);
    check("R9 no extra request", {31'h0, bus_req_valid}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule